// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets an on-chip host read and write an external asynchronous static RAM of 512K locations by 8 bits. The host raises a request with an address, a read/write flag and write data, and holds it until the controller returns a one-cycle acknowledge. For reads, the returned data arrives with that acknowledge. On the memory side the controller drives a 19-bit address, three active-low strobes (chip enable, output enable, write enable) and a shared 8-bit data bus. The data bus is brought out as separate output, output-enable and input pins for the pad ring.

The memory has no clock, so every strobe phase is timed by counting clock cycles. The clock period in nanoseconds is a parameter. Each phase lasts the smallest whole number of cycles that covers its limit, and never less than one cycle. These limits are the read access time, the write pulse, the chip-enable and address windows before the end of a write, the data setup before the end of a write, the minimum cycle times and the time the memory keeps driving after its outputs are disabled.

With the default 8 ns clock the phase lengths are as follows. A read holds its strobes low for 4 cycles. A write pulse lasts 3 cycles inside a 4-cycle write cycle. After a read, 2 cycles of bus float pass before another cycle may begin.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is high, chip enable, write enable and output enable are all high, the data bus is undriven and acknowledge is low.
- R2: A read holds chip enable and output enable low, with write enable high, for exactly N_RD cycles from the cycle after acceptance. N_RD is the largest of ceil(25/T), ceil(25/T) and ceil(12/T), where T is the clock period; N_RD is 4 at 8 ns.
- R3: Read data is sampled on the edge that ends the read strobes and is presented on the host read-data port during the single acknowledge cycle that follows. It equals the byte last written to that address.
- R4: A write holds chip enable and write enable low together for exactly N_WP cycles. N_WP is the largest of ceil(15/T), ceil(17/T) and ceil(12/T), which is 3 at 8 ns. Output enable stays high for the whole write.
- R5: The data bus is driven only while write enable and chip enable are low, never while output enable is low, and carries the host's write data.
- R6: A write is acknowledged N_WC cycles after the cycle in which it is accepted. N_WC is the larger of ceil(25/T) and N_WP, which is 4 at 8 ns.
- R7: After a read's strobes rise, no new memory cycle begins for at least max(N_HZ, 2) cycles, where N_HZ is ceil(12/T).
- R8: Acknowledge is high for exactly one cycle per request. A request still high in that cycle is not taken as a new one. A request held high with new fields is accepted as the next operation without a dead gap beyond R6 and R7.
- R9: The memory address stays constant while chip enable is low and equals the host address of the accepted request.
- R10: Without a request, all strobes stay high and the data bus stays undriven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Host request, held until acknowledged |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 19 | Host word address |
| host_wdata | input | 8 | Host write data |
| host_ack | output | 1 | One-cycle completion pulse |
| host_rdata | output | 8 | Read data, valid with acknowledge |
| mem_addr | output | 19 | Memory address |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_dq_o | output | 8 | Data bus value driven toward memory |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_i | input | 8 | Data bus value received from memory |

## Verification
The bench compares every strobe, the bus enable, the address and the acknowledge against a timeline model on every cycle. It targets the exact strobe lengths: a timer off by one would cut short the write pulse or sample read data before it is valid. It then runs back-to-back operations with the request held through the acknowledge. A design that reused a stale request in the acknowledge cycle, or that skipped the float gap after a read, would start a cycle early and clash with the memory still driving the bus. Reads of never-written and last-written addresses at both ends of the address space show whether a write released the bus too early or latched the wrong address.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_RD_ACC = 3'd1,
    ST_RD_FLT = 3'd2,
    ST_WR_PLS = 3'd3,
    ST_WR_REC = 3'd4
  } sram_st_e;

  // whole clock cycles covering t_ns, never below one
  function automatic int unsigned cycles_for(int unsigned t_ns, int unsigned clk_ns);
    int unsigned c;
    c = (t_ns + clk_ns - 1) / clk_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned bits_for(int unsigned n);
    int unsigned w;
    w = 1;
    while ((1 << w) <= n) w++;
    return w;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
`timescale 1ns/1ps
module sram_phase_timer #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);

  // a loaded count must fall by one each cycle until zero
  a_r2_timer_counts: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/sram_seq_fsm.sv
`timescale 1ns/1ps
module sram_seq_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int CW    = 3,
  parameter int N_RD  = 4,
  parameter int N_WP  = 3,
  parameter int N_REC = 1,
  parameter int N_HZ  = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic          req_we,
  input  logic          tmr_done,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val,
  output logic          ev_accept,
  output logic          ev_wr_end,
  output logic          ev_rd_cap,
  output logic          ce_n,
  output logic          we_n,
  output logic          oe_n,
  output logic          ack
);

  localparam logic [CW-1:0] V_RD  = CW'(N_RD - 1);
  localparam logic [CW-1:0] V_WP  = CW'(N_WP - 1);
  localparam logic [CW-1:0] V_HZ  = CW'(N_HZ - 1);
  localparam logic [CW-1:0] V_REC = CW'((N_REC > 0) ? N_REC - 1 : 0);

  sram_st_e st_q, st_d;
  logic     wr_done;
  logic     can_take;

  assign can_take = req && !ack;

  always_comb begin
    st_d      = st_q;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    ev_accept = 1'b0;
    ev_wr_end = 1'b0;
    ev_rd_cap = 1'b0;
    wr_done   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (can_take) ev_accept = 1'b1;
      end
      ST_RD_ACC: begin
        if (tmr_done) begin
          ev_rd_cap = 1'b1;
          st_d      = ST_RD_FLT;
          tmr_load  = 1'b1;
          tmr_val   = V_HZ;
        end
      end
      ST_RD_FLT: begin
        if (tmr_done) begin
          if (can_take) ev_accept = 1'b1;
          else          st_d      = ST_IDLE;
        end
      end
      ST_WR_PLS: begin
        if (tmr_done) begin
          ev_wr_end = 1'b1;
          if (N_REC > 0) begin
            st_d     = ST_WR_REC;
            tmr_load = 1'b1;
            tmr_val  = V_REC;
          end else begin
            st_d    = ST_IDLE;
            wr_done = 1'b1;
          end
        end
      end
      ST_WR_REC: begin
        if (tmr_done) begin
          st_d    = ST_IDLE;
          wr_done = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
    if (ev_accept) begin
      tmr_load = 1'b1;
      if (req_we) begin
        st_d    = ST_WR_PLS;
        tmr_val = V_WP;
      end else begin
        st_d    = ST_RD_ACC;
        tmr_val = V_RD;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= ST_IDLE;
      ce_n <= 1'b1;
      we_n <= 1'b1;
      oe_n <= 1'b1;
      ack  <= 1'b0;
    end else begin
      st_q <= st_d;
      ack  <= ev_rd_cap || wr_done;
      if (ev_accept) begin
        ce_n <= 1'b0;
        we_n <= !req_we;
        oe_n <= req_we;
      end else begin
        if (ev_rd_cap || ev_wr_end) ce_n <= 1'b1;
        if (ev_wr_end)              we_n <= 1'b1;
        if (ev_rd_cap)              oe_n <= 1'b1;
      end
    end
  end

  // strobe-length watchers for the assertions
  logic [7:0] we_low_q, oe_low_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      we_low_q <= '0;
      oe_low_q <= '0;
    end else begin
      we_low_q <= (!we_n && we_low_q != 8'hFF) ? we_low_q + 8'd1 : (we_n ? 8'd0 : we_low_q);
      oe_low_q <= (!oe_n && oe_low_q != 8'hFF) ? oe_low_q + 8'd1 : (oe_n ? 8'd0 : oe_low_q);
    end
  end

  a_r4_wp_len: assert property (@(posedge clk) disable iff (rst)
    $rose(we_n) |-> (we_low_q == 8'(N_WP)));

  a_r2_rd_len: assert property (@(posedge clk) disable iff (rst)
    $rose(oe_n) |-> (oe_low_q == 8'(N_RD)));

  a_r8_ack_single: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack);

  a_r4_oe_high_in_write: assert property (@(posedge clk) disable iff (rst)
    !we_n |-> (oe_n && !ce_n));

endmodule

// File: rtl/sram_data_path.sv
`timescale 1ns/1ps
module sram_data_path #(
  parameter int AW = 19,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ev_accept,
  input  logic          ev_wr_end,
  input  logic          ev_rd_cap,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] dq_in,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] dq_out,
  output logic          dq_drive,
  output logic [DW-1:0] rdata_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q   <= '0;
      dq_out   <= '0;
      dq_drive <= 1'b0;
      rdata_q  <= '0;
    end else begin
      if (ev_accept) addr_q <= req_addr;
      if (ev_accept && req_we) begin
        dq_out   <= req_wdata;
        dq_drive <= 1'b1;
      end else if (ev_wr_end) begin
        dq_drive <= 1'b0;
      end
      if (ev_rd_cap) rdata_q <= dq_in;
    end
  end

endmodule

// File: rtl/sram_async_ctrl.sv
`timescale 1ns/1ps
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int AW     = 19,
  parameter int DW     = 8,
  parameter int CLK_NS = 8,
  parameter int T_RC   = 25,
  parameter int T_AA   = 25,
  parameter int T_OE   = 12,
  parameter int T_WC   = 25,
  parameter int T_WP   = 15,
  parameter int T_CW   = 17,
  parameter int T_AW   = 17,
  parameter int T_DS   = 12,
  parameter int T_HZ   = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_req,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic          host_ack,
  output logic [DW-1:0] host_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic [DW-1:0] mem_dq_o,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_i
);

  localparam int N_RD  = int'(max2(cycles_for(T_RC, CLK_NS),
                              max2(cycles_for(T_AA, CLK_NS), cycles_for(T_OE, CLK_NS))));
  localparam int N_WP  = int'(max2(cycles_for(T_WP, CLK_NS),
                              max2(max2(cycles_for(T_CW, CLK_NS), cycles_for(T_AW, CLK_NS)),
                                   cycles_for(T_DS, CLK_NS))));
  localparam int N_WC  = int'(max2(cycles_for(T_WC, CLK_NS), N_WP));
  localparam int N_REC = N_WC - N_WP;
  localparam int N_HZ  = int'(cycles_for(T_HZ, CLK_NS));
  localparam int N_MAX = int'(max2(max2(N_RD, N_WP), max2(N_REC, N_HZ)));
  localparam int CW    = int'(bits_for(N_MAX));

  // internal events, named for the assertions
  logic          tmr_load, tmr_done;
  logic [CW-1:0] tmr_val;
  logic          ev_accept, ev_wr_end, ev_rd_cap;

  sram_phase_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  sram_seq_fsm #(
    .CW(CW), .N_RD(N_RD), .N_WP(N_WP), .N_REC(N_REC), .N_HZ(N_HZ)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .req       (host_req),
    .req_we    (host_we),
    .tmr_done  (tmr_done),
    .tmr_load  (tmr_load),
    .tmr_val   (tmr_val),
    .ev_accept (ev_accept),
    .ev_wr_end (ev_wr_end),
    .ev_rd_cap (ev_rd_cap),
    .ce_n      (mem_ce_n),
    .we_n      (mem_we_n),
    .oe_n      (mem_oe_n),
    .ack       (host_ack)
  );

  sram_data_path #(.AW(AW), .DW(DW)) u_data (
    .clk       (clk),
    .rst       (rst),
    .ev_accept (ev_accept),
    .ev_wr_end (ev_wr_end),
    .ev_rd_cap (ev_rd_cap),
    .req_we    (host_we),
    .req_addr  (host_addr),
    .req_wdata (host_wdata),
    .dq_in     (mem_dq_i),
    .addr_q    (mem_addr),
    .dq_out    (mem_dq_o),
    .dq_drive  (mem_dq_oe),
    .rdata_q   (host_rdata)
  );

  // cycles since output enable last went high, saturating
  logic [CW:0] hz_cnt_q;
  always_ff @(posedge clk) begin
    if (rst)                       hz_cnt_q <= (CW+1)'(N_HZ);
    else if (!mem_oe_n)            hz_cnt_q <= '0;
    else if (hz_cnt_q < (CW+1)'(N_HZ)) hz_cnt_q <= hz_cnt_q + 1'b1;
  end

  a_r7_float_gap: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_ce_n) |-> (hz_cnt_q >= (CW+1)'(N_HZ)));

  a_r5_no_contention: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> mem_oe_n);

  a_r5_drive_in_pulse: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> (!mem_we_n && !mem_ce_n));

  a_r9_addr_stable: assert property (@(posedge clk) disable iff (rst)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

  a_r2_read_mode: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> (!mem_ce_n && mem_we_n && !mem_dq_oe));

endmodule

// File: tb/tb_sram_async_ctrl.sv
`timescale 1ns/1ps
module tb_sram_async_ctrl;

  localparam int CLK_NS = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic        hwe = 1'b0;
  logic [18:0] haddr = '0;
  logic [7:0]  hwd = '0;
  logic        host_ack;
  logic [7:0]  host_rdata;
  logic [18:0] mem_addr;
  logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [7:0]  mem_dq_o;
  logic [7:0]  mem_dq_i = 8'hC3;

  always #4 clk = ~clk;

  sram_async_ctrl dut (
    .clk(clk), .rst(rst), .host_req(req), .host_we(hwe), .host_addr(haddr),
    .host_wdata(hwd), .host_ack(host_ack), .host_rdata(host_rdata),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
    .mem_dq_i(mem_dq_i)
  );

  int checks = 0, errors = 0, cyc = 0;
  bit done_flag = 0;

  function automatic int need(int t);
    int k = 1;
    while (k * CLK_NS < t) k++;
    return k;
  endfunction
  function automatic int mx(int a, int b);
    return (a > b) ? a : b;
  endfunction

  int n_rd, n_wp, n_wc, n_hz;
  initial begin
    n_rd = mx(need(25), need(12));
    n_wp = mx(need(15), mx(need(17), need(12)));
    n_wc = mx(need(25), n_wp);
    n_hz = need(12);
  end

  // memory contents: never-written locations hold a fixed function of the address
  function automatic logic [7:0] fill(logic [18:0] a);
    return a[7:0] ^ a[18:11] ^ 8'hA5;
  endfunction
  logic [7:0] smem[int];     // behavioural SRAM
  logic [7:0] scoreb[int];   // host-side expectation
  function automatic logic [7:0] smem_rd(logic [18:0] a);
    return smem.exists(int'(a)) ? smem[int'(a)] : fill(a);
  endfunction
  function automatic logic [7:0] score_rd(logic [18:0] a);
    return scoreb.exists(int'(a)) ? scoreb[int'(a)] : fill(a);
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // reference timeline
  int rd_s = -1000, wr_s = -1000, busy = 0;
  logic [18:0] m_addr = '0;
  logic [7:0]  m_wd = '0, m_exp = '0;

  always @(posedge clk) begin
    cyc++;
    if (!rst && req && cyc >= busy) begin
      m_addr = haddr;
      if (hwe) begin
        wr_s = cyc; m_wd = hwd; busy = cyc + n_wc + 2;
        scoreb[int'(haddr)] = hwd;
      end else begin
        rd_s = cyc; m_exp = score_rd(haddr); busy = cyc + n_rd + mx(n_hz, 2);
      end
    end
    if (cyc > 50000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 50000);
      finish_run();
    end
  end

  bit          pw_low = 0;
  logic [18:0] pw_addr = '0;
  logic [7:0]  pw_data = '0;

  always @(negedge clk) begin
    if (!rst) begin
      bit ra, wa, e_ack;
      string ttag;
      ra = (cyc >= rd_s) && (cyc < rd_s + n_rd);
      wa = (cyc >= wr_s) && (cyc < wr_s + n_wp);
      ttag = ra ? "R2" : wa ? "R4" : (cyc < rd_s + n_rd + mx(n_hz, 2)) ? "R7" : "R10";
      chk(mem_ce_n == !(ra || wa), ttag, "ce_n", mem_ce_n, !(ra || wa));
      chk(mem_oe_n == !ra, ra ? "R2" : wa ? "R4" : "R10", "oe_n", mem_oe_n, !ra);
      chk(mem_we_n == !wa, ra ? "R2" : wa ? "R4" : "R10", "we_n", mem_we_n, !wa);
      chk(mem_dq_oe == wa, wa ? "R5" : "R10", "dq_oe", mem_dq_oe, wa);
      if (ra || wa) chk(mem_addr == m_addr, "R9", "addr", mem_addr, m_addr);
      if (wa && mem_dq_oe) chk(mem_dq_o == m_wd, "R5", "dq_o", mem_dq_o, m_wd);
      e_ack = (cyc == rd_s + n_rd) || (cyc == wr_s + n_wc);
      chk(host_ack == e_ack, (cyc == rd_s + n_rd) ? "R3" : (cyc == wr_s + n_wc) ? "R6" : "R8",
          "ack", host_ack, e_ack);
      if (cyc == rd_s + n_rd) chk(host_rdata == m_exp, "R3", "rdata", host_rdata, m_exp);
    end
    // behavioural SRAM: a write lands when the write enable / chip enable overlap ends
    if (pw_low && (mem_we_n || mem_ce_n)) smem[int'(pw_addr)] = pw_data;
    pw_low  = !mem_we_n && !mem_ce_n && mem_dq_oe;
    pw_addr = mem_addr;
    pw_data = mem_dq_o;
    mem_dq_i = (!mem_ce_n && !mem_oe_n && mem_we_n) ? smem_rd(mem_addr) : 8'hC3;
  end

  task automatic host_op(bit we, logic [18:0] a, logic [7:0] d, bit keep);
    @(negedge clk);
    req = 1; hwe = we; haddr = a; hwd = d;
    do @(negedge clk); while (host_ack !== 1'b1);
    if (!keep) req = 0;
  endtask

  initial begin
    // R1: reset state
    repeat (3) begin
      @(negedge clk);
      chk(mem_ce_n && mem_we_n && mem_oe_n, "R1", "strobes", {mem_ce_n, mem_we_n, mem_oe_n}, 3'b111);
      chk(!mem_dq_oe && !host_ack, "R1", "bus/ack", {mem_dq_oe, host_ack}, 0);
    end
    rst = 0;
    repeat (6) @(negedge clk);               // R10 idle
    host_op(1, 19'h00000, 8'h3C, 0);
    host_op(1, 19'h7FFFF, 8'hC5, 0);
    host_op(0, 19'h00000, 8'h00, 0);          // R3 read back low end
    host_op(0, 19'h7FFFF, 8'h00, 0);          // R3 read back high end
    host_op(0, 19'h12345, 8'h00, 0);          // never written
    repeat (3) @(negedge clk);
    // R8 back-to-back with request held
    host_op(1, 19'h2AAAA, 8'h5A, 1);
    host_op(0, 19'h2AAAA, 8'h00, 1);          // R7 float gap follows
    host_op(0, 19'h55555, 8'h00, 1);
    host_op(1, 19'h55555, 8'hE7, 1);
    host_op(1, 19'h55556, 8'h18, 1);
    host_op(0, 19'h55555, 8'h00, 1);
    host_op(0, 19'h55556, 8'h00, 0);
    for (int i = 0; i < 6; i++) host_op(1, 19'(i * 4099), 8'(i * 37 + 1), 0);
    for (int i = 0; i < 6; i++) host_op(0, 19'(i * 4099), 8'h00, i[0]);
    req = 0;
    repeat (8) @(negedge clk);               // R10 idle again
    finish_run();
  end

endmodule